// File: doc/BRIEF.md
# Serial EEPROM Read Sequencer

This block fetches a run of bytes from a serial EEPROM over a four-wire serial bus by driving the clock, select and outgoing data lines directly from logic. A request gives a byte offset and a byte count. The block adds the offset to a stored base offset and takes ownership of the bus. It frames a read command with a two-byte address, then clocks in the requested bytes back to back and hands each one out with a one-cycle strobe. At the end it gives the bus back.

Before touching the bus, the block checks two device flags and the range of the base offset. A rejected request ends at once with an error code, and the bus lines do not move. Ownership and select are always taken and dropped in a fixed two-step order. Each step lasts one serial half period, so the EEPROM never sees select change while the bus is not owned. A parameter sets the half period in system clocks.

Top module: `eeprom_rd_seq`

## Requirements
- R1: While reset is high and right after it, busy, done, rd_valid and bus_own are 0, sel_n is 1 and ser_clk is 0.
- R2: At the start of a transfer, bus_own rises while sel_n is still 1. sel_n falls exactly HALF_DIV clocks later, with ser_clk low, and is never low unless bus_own is 1.
- R3: At the end of a transfer, sel_n rises first while bus_own is still 1. bus_own falls exactly HALF_DIV clocks later. When done pulses, bus_own is 0, sel_n is 1 and ser_clk is 0.
- R4: Outgoing bits go most significant bit first. ser_out is set while ser_clk is low and holds steady while ser_clk is high. ser_clk only toggles while sel_n is 0.
- R5: ser_in is sampled in the last system cycle of each ser_clk high phase. Each sample shifts into the least significant end, so eight ser_clk pulses make one received byte.
- R6: Every accepted request sends the bytes 0x03, address high, address low on the bus, then clocks in exactly req_count bytes.
- R7: The bus address is (req_offset + base_offset[15:0]) modulo 2^16. Data bytes come from consecutive addresses, which wrap from 0xFFFF to 0x0000.
- R8: A base_offset above 0xFFFF is rejected: done pulses in the cycle after start, err_code is 2, and bus_own never rises.
- R9: If dev_present is 0 or dev_absent is 1, the request is rejected with err_code 1. This check takes precedence over R8 and leaves the bus idle.
- R10: Every ser_clk high phase lasts exactly HALF_DIV system clocks.
- R11: busy is 1 from the cycle after an accepted start until done. rd_valid is a one-cycle strobe per byte with the byte on rd_data. done is a one-cycle pulse with err_code 0 on success. A start while busy is ignored.
- R12: With req_count 0, the full select, command and address frame and the release still happen. rd_valid never pulses and done follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request pulse |
| req_offset | input | ADDR_W | Byte offset relative to the base |
| req_count | input | CNT_W | Number of bytes to read |
| base_offset | input | BASE_W | Stored base offset, range checked |
| dev_present | input | 1 | Device-present flag, must be 1 |
| dev_absent | input | 1 | Not-present flag, must be 0 |
| busy | output | 1 | Transfer in progress |
| rd_data | output | 8 | Received byte |
| rd_valid | output | 1 | rd_data strobe |
| done | output | 1 | End-of-request pulse |
| err_code | output | 2 | 0 ok, 1 no device, 2 base out of range; valid with done |
| bus_own | output | 1 | Bus ownership enable |
| sel_n | output | 1 | EEPROM chip select, active low |
| ser_clk | output | 1 | Serial clock |
| ser_out | output | 1 | Data to the EEPROM |
| ser_in | input | 1 | Data from the EEPROM |

## Verification
A behavioural EEPROM model answers from an address-derived pattern, so a shifted, reversed or misaddressed byte shows up as a wrong value. The requests used are a single byte, a multi-byte run with a nonzero base, runs that wrap past 0xFFFF (one from a large offset, one from a large base), a zero count, and the largest legal base. Together they separate address arithmetic errors from framing errors and count errors. Rejected requests cover each flag, both flags together with a bad base (to test precedence), and a base one above the limit. A second start during a transfer checks that it has no effect. Throughout, a monitor measures the ownership and select spacing and the serial clock high width.

// File: rtl/eeprom_rd_pkg.sv
package eeprom_rd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_OWN, ST_SEL, ST_XFER, ST_DESEL, ST_DROP
  } seq_st_t;

  typedef enum logic [1:0] {
    PH_CMD, PH_ADDR, PH_DATA
  } frame_ph_t;

  typedef enum logic [1:0] {
    BS_IDLE, BS_LOW, BS_HIGH
  } bit_st_t;

  localparam logic [1:0] ERR_NONE  = 2'd0;
  localparam logic [1:0] ERR_NODEV = 2'd1;
  localparam logic [1:0] ERR_RANGE = 2'd2;

  localparam logic [7:0] CMD_READ = 8'h03;

endpackage

// File: rtl/eeprom_half_timer.sv
module eeprom_half_timer #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt;

  assign tick = en && (cnt == CW'(HALF_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/eeprom_bit_shifter.sv
module eeprom_bit_shifter
  import eeprom_rd_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int BYTE_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              miso,
  output logic              sck,
  output logic              mosi,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              byte_done
);
  localparam int IW = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;

  bit_st_t           st;
  logic [BYTE_W-1:0] tx_sh;
  logic [IW-1:0]     bit_idx;
  logic              tick;

  eeprom_half_timer #(.HALF_DIV(HALF_DIV)) u_tmr (
    .clk  (clk),
    .rst  (rst),
    .en   (st != BS_IDLE),
    .tick (tick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= BS_IDLE;
      tx_sh     <= '0;
      rx_byte   <= '0;
      bit_idx   <= '0;
      sck       <= 1'b0;
      mosi      <= 1'b0;
      byte_done <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      unique case (st)
        BS_IDLE: begin
          if (go) begin
            tx_sh   <= tx_byte;
            mosi    <= tx_byte[BYTE_W-1];
            bit_idx <= '0;
            st      <= BS_LOW;
          end
        end
        BS_LOW: begin
          if (tick) begin
            sck <= 1'b1;
            st  <= BS_HIGH;
          end
        end
        BS_HIGH: begin
          if (tick) begin
            rx_byte <= {rx_byte[BYTE_W-2:0], miso};
            sck     <= 1'b0;
            if (bit_idx == IW'(BYTE_W - 1)) begin
              byte_done <= 1'b1;
              st        <= BS_IDLE;
            end else begin
              bit_idx <= bit_idx + 1'b1;
              tx_sh   <= tx_sh << 1;
              mosi    <= tx_sh[BYTE_W-2];
              st      <= BS_LOW;
            end
          end
        end
        default: st <= BS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/eeprom_rd_seq.sv
module eeprom_rd_seq
  import eeprom_rd_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int CNT_W    = 8,
  parameter int BASE_W   = 32,
  parameter int HALF_DIV = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] req_offset,
  input  logic [CNT_W-1:0]  req_count,
  input  logic [BASE_W-1:0] base_offset,
  input  logic              dev_present,
  input  logic              dev_absent,
  output logic              busy,
  output logic [7:0]        rd_data,
  output logic              rd_valid,
  output logic              done,
  output logic [1:0]        err_code,
  output logic              bus_own,
  output logic              sel_n,
  output logic              ser_clk,
  output logic              ser_out,
  input  logic              ser_in
);
  localparam int BYTE_W     = 8;
  localparam int ADDR_BYTES = ADDR_W / BYTE_W;
  localparam int AB_W       = $clog2(ADDR_BYTES + 1);
  localparam logic [BASE_W-1:0] MAX_BASE = BASE_W'((64'd1 << ADDR_W) - 64'd1);

  seq_st_t           st;
  frame_ph_t         ph;
  logic [ADDR_W-1:0] addr_sh;
  logic [CNT_W-1:0]  left_q;
  logic [AB_W-1:0]   ab_left;
  logic              sh_go;
  logic [BYTE_W-1:0] sh_tx;
  logic [BYTE_W-1:0] sh_rx;
  logic              sh_done;
  logic              step_tick;
  logic              step_en;

  assign step_en = (st == ST_OWN) || (st == ST_SEL) ||
                   (st == ST_DESEL) || (st == ST_DROP);

  eeprom_half_timer #(.HALF_DIV(HALF_DIV)) u_step (
    .clk  (clk),
    .rst  (rst),
    .en   (step_en),
    .tick (step_tick)
  );

  eeprom_bit_shifter #(.HALF_DIV(HALF_DIV), .BYTE_W(BYTE_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .go        (sh_go),
    .tx_byte   (sh_tx),
    .miso      (ser_in),
    .sck       (ser_clk),
    .mosi      (ser_out),
    .rx_byte   (sh_rx),
    .byte_done (sh_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      ph       <= PH_CMD;
      addr_sh  <= '0;
      left_q   <= '0;
      ab_left  <= '0;
      sh_go    <= 1'b0;
      sh_tx    <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
      err_code <= ERR_NONE;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      bus_own  <= 1'b0;
      sel_n    <= 1'b1;
    end else begin
      done     <= 1'b0;
      rd_valid <= 1'b0;
      sh_go    <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (start) begin
            if (!dev_present || dev_absent) begin
              err_code <= ERR_NODEV;
              done     <= 1'b1;
            end else if (base_offset > MAX_BASE) begin
              err_code <= ERR_RANGE;
              done     <= 1'b1;
            end else begin
              err_code <= ERR_NONE;
              addr_sh  <= req_offset + base_offset[ADDR_W-1:0];
              left_q   <= req_count;
              busy     <= 1'b1;
              bus_own  <= 1'b1;
              st       <= ST_OWN;
            end
          end
        end
        ST_OWN: begin
          if (step_tick) begin
            sel_n <= 1'b0;
            st    <= ST_SEL;
          end
        end
        ST_SEL: begin
          if (step_tick) begin
            sh_go <= 1'b1;
            sh_tx <= CMD_READ;
            ph    <= PH_CMD;
            st    <= ST_XFER;
          end
        end
        ST_XFER: begin
          if (sh_done) begin
            unique case (ph)
              PH_CMD: begin
                sh_go   <= 1'b1;
                sh_tx   <= addr_sh[ADDR_W-1 -: BYTE_W];
                addr_sh <= addr_sh << BYTE_W;
                ab_left <= AB_W'(ADDR_BYTES - 1);
                ph      <= PH_ADDR;
              end
              PH_ADDR: begin
                if (ab_left != '0) begin
                  sh_go   <= 1'b1;
                  sh_tx   <= addr_sh[ADDR_W-1 -: BYTE_W];
                  addr_sh <= addr_sh << BYTE_W;
                  ab_left <= ab_left - 1'b1;
                end else if (left_q == '0) begin
                  sel_n <= 1'b1;
                  st    <= ST_DESEL;
                end else begin
                  sh_go <= 1'b1;
                  sh_tx <= '0;
                  ph    <= PH_DATA;
                end
              end
              default: begin
                rd_data  <= sh_rx;
                rd_valid <= 1'b1;
                left_q   <= left_q - 1'b1;
                if (left_q == CNT_W'(1)) begin
                  sel_n <= 1'b1;
                  st    <= ST_DESEL;
                end else begin
                  sh_go <= 1'b1;
                  sh_tx <= '0;
                end
              end
            endcase
          end
        end
        ST_DESEL: begin
          if (step_tick) begin
            bus_own <= 1'b0;
            st      <= ST_DROP;
          end
        end
        ST_DROP: begin
          if (step_tick) begin
            busy <= 1'b0;
            done <= 1'b1;
            st   <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/eeprom_rd_seq_chk.sv
module eeprom_rd_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       busy,
  input logic       done,
  input logic       rd_valid,
  input logic [1:0] err_code,
  input logic       bus_own,
  input logic       sel_n,
  input logic       ser_clk,
  input logic       ser_out
);
  AST_SEL_NEEDS_OWN: assert property (@(posedge clk) disable iff (rst)
    !sel_n |-> bus_own);                                            // R2
  AST_SEL_AFTER_OWN: assert property (@(posedge clk) disable iff (rst)
    $fell(sel_n) |-> $past(bus_own));                               // R2
  AST_OWN_DROP_AFTER_DESEL: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_own) |-> $past(sel_n));                               // R3
  AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (rst)
    done |-> (!bus_own && sel_n && !ser_clk && !busy));             // R3
  AST_SCK_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    ser_clk |-> !sel_n);                                            // R4
  AST_MOSI_HOLD_HIGH: assert property (@(posedge clk) disable iff (rst)
    (ser_clk && $past(ser_clk)) |-> $stable(ser_out));              // R4
  AST_ERR_NO_OWN: assert property (@(posedge clk) disable iff (rst)
    (done && err_code != 2'd0) |-> !bus_own);                       // R8
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);                                        // R11
  AST_VALID_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> busy);                                             // R11
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);                                                // R11
endmodule

bind eeprom_rd_seq eeprom_rd_seq_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .busy     (busy),
  .done     (done),
  .rd_valid (rd_valid),
  .err_code (err_code),
  .bus_own  (bus_own),
  .sel_n    (sel_n),
  .ser_clk  (ser_clk),
  .ser_out  (ser_out)
);

// File: tb/tb_eeprom_rd_seq.sv
`timescale 1ns/1ps
module tb_eeprom_rd_seq;
  localparam int HALF = 3;
  localparam int NV   = 6;
  // {offset[15:0], count[7:0], base[31:0]}
  localparam logic [55:0] VEC [NV] = '{
    56'h0000_01_00000000,
    56'h0010_04_00000100,
    56'hFFFE_03_00000001,
    56'h1234_00_00000020,
    56'h0001_02_0000FFFF,
    56'h00FF_02_0000FF00
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] req_offset = '0;
  logic [7:0]  req_count = '0;
  logic [31:0] base_offset = '0;
  logic        dev_present = 1'b1;
  logic        dev_absent = 1'b0;
  logic        busy, rd_valid, done, bus_own, sel_n, ser_clk, ser_out;
  logic [7:0]  rd_data;
  logic [1:0]  err_code;
  logic        ser_in = 1'b0;

  always #2 clk = ~clk;

  eeprom_rd_seq #(.HALF_DIV(HALF)) dut (
    .clk(clk), .rst(rst), .start(start), .req_offset(req_offset),
    .req_count(req_count), .base_offset(base_offset),
    .dev_present(dev_present), .dev_absent(dev_absent), .busy(busy),
    .rd_data(rd_data), .rd_valid(rd_valid), .done(done),
    .err_code(err_code), .bus_own(bus_own), .sel_n(sel_n),
    .ser_clk(ser_clk), .ser_out(ser_out), .ser_in(ser_in)
  );

  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    return a[7:0] ^ {a[14:8], a[15]} ^ 8'hA5;
  endfunction

  // EEPROM model
  int          bitcnt = 0;
  logic [23:0] hdr = '0;
  always @(posedge ser_clk or posedge sel_n) begin
    if (sel_n) bitcnt <= 0;
    else begin
      if (bitcnt < 24) hdr <= {hdr[22:0], ser_out};
      bitcnt <= bitcnt + 1;
    end
  end
  always @(negedge ser_clk) begin
    if (!sel_n && bitcnt >= 24) begin
      logic [7:0] b;
      b = mem_byte(hdr[15:0] + 16'((bitcnt - 24) / 8));
      ser_in = b[7 - ((bitcnt - 24) % 8)];
    end
  end

  int checks = 0, errors = 0;
  int mchecks = 0, merrs = 0;
  bit mon_on = 1'b0;
  int own_cnt = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Bus order and timing monitor (single process)
  int  cyc = 0, t_own = 0, t_desel = 0, hi_run = 0;
  logic p_own = 1'b0, p_sel = 1'b1;
  always @(negedge clk) begin
    cyc++;
    if (mon_on) begin
      if (bus_own && !p_own) begin
        own_cnt++; t_own = cyc; mchecks++;
        if (sel_n !== 1'b1) begin merrs++;
          $display("FAIL R2 select low at own rise actual=%b expected=1", sel_n); end
      end
      if (!sel_n && p_sel) begin
        mchecks++;
        if (!(bus_own === 1'b1 && cyc - t_own == HALF && ser_clk === 1'b0)) begin merrs++;
          $display("FAIL R2 select fall spacing actual=%0d expected=%0d", cyc - t_own, HALF); end
      end
      if (sel_n && !p_sel) begin
        t_desel = cyc; mchecks++;
        if (bus_own !== 1'b1) begin merrs++;
          $display("FAIL R3 own dropped before deselect actual=%b expected=1", bus_own); end
      end
      if (!bus_own && p_own) begin
        mchecks++;
        if (!(sel_n === 1'b1 && cyc - t_desel == HALF)) begin merrs++;
          $display("FAIL R3 own fall spacing actual=%0d expected=%0d", cyc - t_desel, HALF); end
      end
      if (ser_clk) hi_run++;
      else if (hi_run != 0) begin
        mchecks++;
        if (hi_run != HALF) begin merrs++;
          $display("FAIL R10 clock high width actual=%0d expected=%0d", hi_run, HALF); end
        hi_run = 0;
      end
    end
    p_own = bus_own;
    p_sel = sel_n;
  end

  logic [7:0] got [32];
  int   nb;
  logic [1:0] ec;
  bit   gd, busy_first;

  task automatic run_req(input logic [15:0] off, input logic [7:0] cnt,
                         input logic [31:0] base, input bit pres,
                         input bit absf, input int poke_at);
    @(negedge clk);
    req_offset = off; req_count = cnt; base_offset = base;
    dev_present = pres; dev_absent = absf; start = 1'b1;
    @(negedge clk);
    start = 1'b0; nb = 0; gd = 1'b0; ec = 2'd3; busy_first = busy;
    for (int c = 0; c < 20000 && !gd; c++) begin
      if (rd_valid) begin
        if (nb < 32) got[nb] = rd_data;
        nb++;
      end
      if (done) begin gd = 1'b1; ec = err_code; end
      if (!gd) begin
        if (c == poke_at) begin start = 1'b1; req_offset = ~off; end
        else start = 1'b0;
        @(negedge clk);
      end
    end
    start = 1'b0;
  endtask

  task automatic check_ok(input logic [15:0] off, input logic [7:0] cnt,
                          input logic [31:0] base);
    logic [15:0] a;
    a = off + base[15:0];
    chk(gd, "R11", "done seen", 32'(gd), 1);
    chk(ec == 2'd0, "R11", "err_code on success", 32'(ec), 0);
    chk(busy_first, "R11", "busy after start", 32'(busy_first), 1);
    chk(nb == int'(cnt), (cnt == 0) ? "R12" : "R6", "byte count", nb, 32'(cnt));
    chk(hdr[23:16] == 8'h03, "R6", "command byte", 32'(hdr[23:16]), 32'h03);
    chk(hdr[15:0] == a, "R7", "bus address", 32'(hdr[15:0]), 32'(a));
    for (int i = 0; i < int'(cnt) && i < 32; i++)
      chk(got[i] == mem_byte(a + 16'(i)), "R5", "data byte", 32'(got[i]),
          32'(mem_byte(a + 16'(i))));
    chk(!bus_own && sel_n && !ser_clk && !busy, "R3", "released at done",
        {28'd0, bus_own, sel_n, ser_clk, busy}, 32'h4);
  endtask

  task automatic check_err(input logic [1:0] exp_ec, input string req, input int own_before);
    chk(gd && ec == exp_ec, req, "reject code", 32'(ec), 32'(exp_ec));
    chk(busy_first == 1'b0, req, "busy stays low", 32'(busy_first), 0);
    repeat (20) @(negedge clk);
    chk(own_cnt == own_before && !bus_own && sel_n, req, "no bus activity",
        own_cnt, own_before);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks + mchecks + 1, errors + merrs + 1);
    $finish;
  end

  initial begin
    int ob;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !rd_valid && !bus_own && sel_n && !ser_clk, "R1",
        "outputs in reset", {26'd0, busy, done, rd_valid, bus_own, sel_n, ser_clk}, 32'h2);
    @(negedge clk); rst = 1'b0; mon_on = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !rd_valid && !bus_own && sel_n && !ser_clk, "R1",
        "outputs after reset", {26'd0, busy, done, rd_valid, bus_own, sel_n, ser_clk}, 32'h2);

    for (int v = 0; v < NV; v++) begin
      run_req(VEC[v][55:40], VEC[v][39:32], VEC[v][31:0], 1'b1, 1'b0, -1);
      check_ok(VEC[v][55:40], VEC[v][39:32], VEC[v][31:0]);
    end

    ob = own_cnt;
    run_req(16'h0005, 8'd2, 32'd0, 1'b0, 1'b0, -1);
    check_err(2'd1, "R9", ob);
    ob = own_cnt;
    run_req(16'h0005, 8'd2, 32'd0, 1'b1, 1'b1, -1);
    check_err(2'd1, "R9", ob);
    ob = own_cnt;
    run_req(16'h0005, 8'd2, 32'h0002_0000, 1'b0, 1'b1, -1);
    check_err(2'd1, "R9", ob);
    ob = own_cnt;
    run_req(16'h0005, 8'd2, 32'h0001_0000, 1'b1, 1'b0, -1);
    check_err(2'd2, "R8", ob);

    // R11: a start during a transfer is ignored
    ob = own_cnt;
    run_req(16'h0040, 8'd2, 32'h10, 1'b1, 1'b0, 30);
    check_ok(16'h0040, 8'd2, 32'h10);
    gd = 1'b0;
    for (int c = 0; c < 300; c++) begin
      @(negedge clk);
      if (done) gd = 1'b1;
    end
    chk(!gd && own_cnt == ob + 1, "R11", "second start ignored", own_cnt - ob, 1);

    repeat (5) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks + mchecks, errors + merrs);
    $finish;
  end
endmodule